// File: doc/BRIEF.md
# Dual-Strobe Burst Address Counter

This block produces the array address for a synchronous burst memory. On each rising clock edge it can capture an external address through either of two active-low address strobes. One strobe is a processor strobe and the other is a controller strobe. If no strobe is asserted, it can instead step a two-bit beat counter when the active-low advance input is low. The upper address bits always come from the captured address. The two low bits follow the burst order chosen by a static mode input: counting up (linear) or XOR with the beat index (interleaved).

A strobe only has effect while the part is selected, which means the active-low enable is low and the active-high enable is high. Bursts are optional. A fresh address can be captured on every cycle without a penalty. A burst of four beats returns to its starting address on the fourth advance, which is the fifth clock counted from the load.

The control is a three-state machine. `ST_IDLE` is the state after reset, before any address has been captured. `ST_RUN` means a load or an advance took place on the last edge. `ST_HOLD` means the burst is suspended because no strobe and no advance were seen.

The transitions are:
- `ST_IDLE` goes to `ST_RUN` on a load. It stays in `ST_IDLE` on an advance, on an idle cycle, or on a strobe while deselected.
- `ST_RUN` or `ST_HOLD` goes to `ST_RUN` on a load or an advance.
- `ST_RUN` or `ST_HOLD` goes to `ST_HOLD` on an idle cycle.
- A deselected strobe leaves the state unchanged in every state.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_o` is all zeros, `active_o` is 0 and `src_o` is 0.
- R2: A strobe (`proc_stb_n` or `ctrl_stb_n` low) while selected (`ce_n`=0 and `ce`=1) captures `addr_i`. From the next edge, `addr_o` equals `addr_i` and `active_o` is 1.
- R3: When both strobes are low in a selected cycle, the processor strobe wins and `src_o` becomes 0. A load through the controller strobe alone sets `src_o` to 1.
- R4: With `interleave_i`=0, the low two bits of `addr_o` after k advances equal (start + k) mod 4.
- R5: With `interleave_i`=1, the low two bits of `addr_o` after k advances equal start XOR (k mod 4).
- R6: The fourth advance after a load brings `addr_o` back to the captured address.
- R7: A cycle with both strobes high and `adv_n` high leaves `addr_o` unchanged (suspend), and a later advance resumes the sequence.
- R8: During a burst, `addr_o[ADDR_W-1:2]` stays equal to the captured upper bits.
- R9: A strobe while deselected (`ce_n`=1 or `ce`=0) changes neither `addr_o`, `active_o` nor `src_o`, even if `adv_n` is low in the same cycle.
- R10: An advance before any load has no effect: `addr_o` stays zero and `active_o` stays 0.
- R11: A selected strobe together with `adv_n` low performs a load with the beat index at 0, not an advance.
- R12: Loads on consecutive cycles each take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| proc_stb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| ce | input | 1 | Chip enable, active high |
| interleave_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External address |
| addr_o | output | ADDR_W | Current array address |
| active_o | output | 1 | An address has been captured since reset |
| src_o | output | 1 | Last load came from the controller strobe |

## Verification
A load and an advance can fall in the same cycle, and so can the two strobes together. The bench provokes both cases by holding `adv_n` low during strobe cycles, both in the middle of running bursts and with both strobes asserted. It then checks that the address restarts at the new captured value with beat zero and that the source flag shows the processor strobe. The same overlap is repeated with the part deselected, where the bench requires that neither the load nor the advance takes effect.

// File: rtl/bac_pkg.sv
package bac_pkg;
    localparam int unsigned BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } bac_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_ADV   = 2'd2,
        CMD_BLOCK = 2'd3
    } bac_cmd_e;
endpackage

// File: rtl/bac_cmd_decode.sv
module bac_cmd_decode
    import bac_pkg::*;
(
    input  logic     proc_stb_n,
    input  logic     ctrl_stb_n,
    input  logic     adv_n,
    input  logic     ce_n,
    input  logic     ce,
    output bac_cmd_e cmd,
    output logic     from_ctrl
);
    logic selected;
    logic any_stb;

    always_comb begin
        selected  = !ce_n && ce;
        any_stb   = !proc_stb_n || !ctrl_stb_n;
        // processor strobe has priority; controller is the source only when alone
        from_ctrl = proc_stb_n;
        if (any_stb) begin
            cmd = selected ? CMD_LOAD : CMD_BLOCK;
        end else if (!adv_n) begin
            cmd = CMD_ADV;
        end else begin
            cmd = CMD_NONE;
        end
    end
endmodule

// File: rtl/bac_order.sv
module bac_order
    import bac_pkg::*;
(
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    always_comb begin
        lin_low = start + beat;
        ilv_low = start ^ beat;
        low     = interleave ? ilv_low : lin_low;
    end
endmodule

// File: rtl/bac_fsm.sv
module bac_fsm
    import bac_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bac_cmd_e          cmd,
    input  logic              from_ctrl,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base,
    output logic [BEAT_W-1:0] beat,
    output logic              src,
    output logic              active
);
    bac_state_e state_q;
    bac_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd == CMD_LOAD) state_d = ST_RUN;
            end
            ST_RUN, ST_HOLD: begin
                unique case (cmd)
                    CMD_LOAD, CMD_ADV: state_d = ST_RUN;
                    CMD_NONE:          state_d = ST_HOLD;
                    CMD_BLOCK:         state_d = state_q;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active = (state_q != ST_IDLE);
    end

    // address and beat registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
            beat <= '0;
            src  <= 1'b0;
        end else if (cmd == CMD_LOAD) begin
            base <= addr_i;
            beat <= '0;
            src  <= from_ctrl;
        end else if (cmd == CMD_ADV && state_q != ST_IDLE) begin
            beat <= beat + BEAT_W'(1);
        end
    end

    a_r2_load_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (active && beat == '0));

    a_r7_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE) |=> ($stable(beat) && $stable(base)));

    a_r8_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_LOAD) |=> $stable(base));

    a_r6_beat_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ADV && active) |=> (beat == $past(beat) + BEAT_W'(1)));

    a_r10_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && cmd != CMD_LOAD) |=> !active);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bac_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              interleave_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              active_o,
    output logic              src_o
);
    localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

    bac_cmd_e          cmd;
    logic              from_ctrl;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;

    bac_cmd_decode u_dec (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .adv_n      (adv_n),
        .ce_n       (ce_n),
        .ce         (ce),
        .cmd        (cmd),
        .from_ctrl  (from_ctrl)
    );

    bac_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .from_ctrl (from_ctrl),
        .addr_i    (addr_i),
        .base      (base),
        .beat      (beat),
        .src       (src_o),
        .active    (active_o)
    );

    bac_order u_ord (
        .start      (base[BEAT_W-1:0]),
        .beat       (beat),
        .interleave (interleave_i),
        .low        (low)
    );

    always_comb begin
        addr_o = {base[ADDR_W-1:BEAT_W], low};
    end

    a_r9_deselect_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((!proc_stb_n || !ctrl_stb_n) && !(!ce_n && ce))
        |=> ($stable(addr_o) && $stable(active_o) && $stable(src_o)));

    a_r3_proc_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && !ctrl_stb_n && !ce_n && ce) |=> !src_o);

    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && proc_stb_n && ctrl_stb_n && !adv_n && !interleave_i)
        |=> (interleave_i || addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + BEAT_W'(1)));

    a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_stb_n && ctrl_stb_n)
        |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

    if (UPPER_W < 1) begin : g_width_check
        initial $error("ADDR_W must exceed the beat width");
    end
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
    logic          ce_n = 1'b0, ce = 1'b1, interleave_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic          active_o, src_o;

    int checks = 0;
    int errors = 0;

    // requirement-level model state
    logic [AW-1:0] m_base = '0;
    int            m_k = 0;
    logic          m_act = 1'b0, m_src = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .adv_n(adv_n), .ce_n(ce_n), .ce(ce), .interleave_i(interleave_i),
        .addr_i(addr_i), .addr_o(addr_o), .active_o(active_o), .src_o(src_o)
    );

    function automatic logic [AW-1:0] expect_addr();
        logic [1:0] s;
        logic [1:0] k;
        s = m_base[1:0];
        k = 2'(m_k % 4);
        return {m_base[AW-1:2], (interleave_i ? (s ^ k) : 2'((s + k) % 4))};
    endfunction

    task automatic check(input string req);
        logic [AW-1:0] e;
        e = expect_addr();
        checks++;
        if (addr_o !== e || active_o !== m_act || src_o !== m_src) begin
            errors++;
            $display("FAIL %s: addr=%h act=%b src=%b expected addr=%h act=%b src=%b",
                     req, addr_o, active_o, src_o, e, m_act, m_src);
        end
    endtask

    // drive one cycle, update model, clock, check
    task automatic cyc(input logic p, input logic c, input logic a, input logic cen,
                       input logic cep, input logic [AW-1:0] ad, input string req);
        proc_stb_n = p; ctrl_stb_n = c; adv_n = a; ce_n = cen; ce = cep; addr_i = ad;
        if (!p || !c) begin
            if (!cen && cep) begin
                m_base = ad; m_k = 0; m_act = 1'b1; m_src = p;
            end
        end else if (!a && m_act) begin
            m_k++;
        end
        @(posedge clk); #1;
        check(req);
    endtask

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state");
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R10: advance before any load
        cyc(1, 1, 0, 0, 1, 8'h00, "R10 idle advance");
        cyc(1, 1, 0, 0, 1, 8'h00, "R10 idle advance");
        // exhaustive sweep of mode and start value
        for (int mode = 0; mode < 2; mode++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] ad;
                ad = AW'((s * 37 + mode * 91 + 8) & 8'hFC) | AW'(s);
                interleave_i = mode[0];
                cyc(s[0], ~s[0], 1, 0, 1, ad, "R2 load");
                cyc(1, 1, 0, 0, 1, ad, mode ? "R5 interleave beat" : "R4 linear beat");
                cyc(1, 1, 0, 0, 1, ad, "R8 upper bits");
                cyc(1, 1, 1, 0, 1, ad, "R7 suspend");
                cyc(1, 1, 1, 0, 1, ad, "R7 suspend");
                cyc(1, 1, 0, 0, 1, ad, mode ? "R5 interleave beat" : "R4 linear beat");
                cyc(1, 1, 0, 0, 1, ad, "R6 wrap");
                if (addr_o !== ad) begin
                    errors++;
                    $display("FAIL R6: addr=%h expected %h", addr_o, ad);
                end
                checks++;
                cyc(1, 1, 0, 0, 1, ad, "R6 after wrap");
            end
        end
        // R3 priority and controller-only source
        cyc(1, 0, 1, 0, 1, 8'h5A, "R3 ctrl source");
        cyc(0, 0, 1, 0, 1, 8'hA7, "R3 proc priority");
        cyc(1, 0, 1, 0, 1, 8'h33, "R3 ctrl source");
        // R9 deselected strobes with advance low
        cyc(0, 1, 0, 1, 1, 8'hFF, "R9 ce_n high");
        cyc(1, 0, 0, 0, 0, 8'hEE, "R9 ce low");
        cyc(0, 0, 0, 1, 0, 8'hDD, "R9 both off");
        // R11 load with advance low mid-burst
        cyc(1, 1, 0, 0, 1, 8'h00, "R4 advance");
        cyc(0, 1, 0, 0, 1, 8'h92, "R11 load beats advance");
        cyc(0, 0, 0, 0, 1, 8'h4D, "R11 both strobes and advance");
        // R12 back-to-back loads in both modes
        for (int i = 0; i < 16; i++) begin
            interleave_i = i[3];
            cyc(i[0], ~i[0], i[1], 0, 1, AW'(i * 29 + 3), "R12 consecutive load");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule